// File: doc/BRIEF.md
# Packed SIMD Unsigned Clamp Unit

This vector execution unit limits every unsigned element of a group of consecutive vector registers to a per-element window. One source register supplies the lower bound of each lane and another supplies the upper bound. A two-bit size control picks the lane width: 8, 16, 32 or 64 bits, which is 8 shifted left by the control. A count control picks a group of two or four destination registers. The result of each lane is written back over the element it came from. There is no predication, so every lane of every register in the group is rewritten.

A command is issued with a start pulse. The pulse carries the lane size, the group count, a group field and the indices of the two bound registers. The first register of the group is the group field times the group count. A sequencer reads one destination register per cycle and clamps it with the same two bound vectors. It keeps each result in a staging buffer. When all results are ready, it writes the whole group in one cycle, so every result is computed from the operand values that existed before the command.

The register file is 32 vectors of a parameter width, 128 bits by default. It is part of the unit and has its own write port and read port for loading and inspecting registers. A group that would run past the last register is refused: the unit raises an error flag together with completion, and no register is written.

Top module: `vclamp_unit`

## Requirements
- R1: The lane width is 8 << cmd_size_i (0→8, 1→16, 2→32, 3→64 bits). A register holds VLEN/width lanes, and no result crosses a lane boundary.
- R2: Each result lane equals min(max(low, elem), high), with every comparison unsigned. Here low and high are the lanes at the same position in registers cmd_lo_idx_i and cmd_hi_idx_i.
- R3: When a lane's low bound is above its high bound, the result of that lane is the high bound.
- R4: With cmd_quad_i=0 the group is registers 2*F and 2*F+1. With cmd_quad_i=1 it is registers 4*F to 4*F+3. F is cmd_group_i. Registers outside the group and outside the bound registers keep their values.
- R5: The same pair of bound vectors is applied to every register in the group.
- R6: Every result is computed from the register contents as they were when the command was accepted. This holds even when a bound register lies inside the group.
- R7: If the last register of the group would have an index above 31, the command ends with done_o and err_o high in the cycle after acceptance, and no register changes.
- R8: For an accepted command of N registers, done_o is a single-cycle pulse first seen N+2 cycles after the start edge, with err_o low. The new register values can be read in that same cycle.
- R9: A start pulse that arrives while busy_o is high is ignored and never produces a second completion.
- R10: After reset busy_o, done_o and err_o are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start_i | input | 1 | Start pulse for a clamp command |
| cmd_size_i | input | 2 | Lane width select |
| cmd_quad_i | input | 1 | 0: two-register group, 1: four-register group |
| cmd_group_i | input | 5 | Group field; base register = field × group count |
| cmd_lo_idx_i | input | 5 | Register holding the lower bounds |
| cmd_hi_idx_i | input | 5 | Register holding the upper bounds |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Group out of range, valid with done_o |
| rf_we_i | input | 1 | External register write enable |
| rf_waddr_i | input | 5 | External write index |
| rf_wdata_i | input | VLEN | External write data |
| rf_raddr_i | input | 5 | External read index |
| rf_rdata_o | output | VLEN | External read data (combinational) |

## Verification
Fixed bound windows are used with random destination data at every lane width. Each lane then falls below, inside or above its window, which checks both the floor and the ceiling in each lane. Wrong lane splitting, signed comparison and carries between lanes all show up here. Crossed windows check that the ceiling wins, since applying min before max would give the floor instead. A group that holds its own bound registers tells a read-then-write order apart from writing in place. Groups at the last legal base, groups one step past it, and a start issued while busy check how the group is chosen and how commands are accepted.

// File: rtl/vclamp_pkg.sv
package vclamp_pkg;
    localparam int GRP_MAX = 4;
    localparam int SIZE_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_COMMIT
    } seq_state_e;
endpackage

// File: rtl/vclamp_regfile.sv
module vclamp_regfile
    import vclamp_pkg::*;
#(
    parameter int VLEN  = 128,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ext_we_i,
    input  logic [AW-1:0]                  ext_waddr_i,
    input  logic [VLEN-1:0]                ext_wdata_i,
    input  logic [AW-1:0]                  ext_raddr_i,
    output logic [VLEN-1:0]                ext_rdata_o,
    input  logic [AW-1:0]                  rd_dst_addr_i,
    output logic [VLEN-1:0]                rd_dst_data_o,
    input  logic [AW-1:0]                  rd_lo_addr_i,
    output logic [VLEN-1:0]                rd_lo_data_o,
    input  logic [AW-1:0]                  rd_hi_addr_i,
    output logic [VLEN-1:0]                rd_hi_data_o,
    input  logic                           cm_en_i,
    input  logic [AW-1:0]                  cm_base_i,
    input  logic [2:0]                     cm_cnt_i,
    input  logic [GRP_MAX-1:0][VLEN-1:0]   cm_data_i
);
    logic [VLEN-1:0] mem_q [NREGS];
    logic [VLEN-1:0] mem_d [NREGS];

    always_comb begin
        mem_d = mem_q;
        if (ext_we_i) begin
            mem_d[ext_waddr_i] = ext_wdata_i;
        end
        if (cm_en_i) begin
            for (int k = 0; k < GRP_MAX; k++) begin
                if (3'(k) < cm_cnt_i) begin
                    mem_d[cm_base_i + AW'(k)] = cm_data_i[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREGS; r++) begin
                mem_q[r] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign ext_rdata_o   = mem_q[ext_raddr_i];
    assign rd_dst_data_o = mem_q[rd_dst_addr_i];
    assign rd_lo_data_o  = mem_q[rd_lo_addr_i];
    assign rd_hi_data_o  = mem_q[rd_hi_addr_i];

    // A group commit from the sequencer never reaches past the last register.
    p_commit_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cm_en_i |-> (int'(cm_base_i) + int'(cm_cnt_i) <= NREGS));
endmodule

// File: rtl/vclamp_lanes.sv
module vclamp_lanes
    import vclamp_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic [SIZE_W-1:0] size_i,
    input  logic [VLEN-1:0]   lo_i,
    input  logic [VLEN-1:0]   hi_i,
    input  logic [VLEN-1:0]   elem_i,
    output logic [VLEN-1:0]   res_o
);
    localparam int NSIZES = 1 << SIZE_W;

    logic [VLEN-1:0] by_size [NSIZES];

    for (genvar g = 0; g < NSIZES; g++) begin : g_width
        localparam int W = 8 << g;
        localparam int L = VLEN / W;
        for (genvar l = 0; l < L; l++) begin : g_lane
            logic [W-1:0] lo_e, hi_e, el_e, up_e, out_e;
            assign lo_e = lo_i[l*W +: W];
            assign hi_e = hi_i[l*W +: W];
            assign el_e = elem_i[l*W +: W];
            always_comb begin
                up_e  = (el_e > lo_e) ? el_e : lo_e;
                out_e = (up_e > hi_e) ? hi_e : up_e;
                p_lane_ceiling_r2: assert (out_e <= hi_e);
                if (lo_e <= hi_e) begin
                    p_lane_floor_r2: assert (out_e >= lo_e);
                end else begin
                    p_cross_high_r3: assert (out_e == hi_e);
                end
            end
            assign by_size[g][l*W +: W] = out_e;
        end
    end

    assign res_o = by_size[size_i];
endmodule

// File: rtl/vclamp_seq.sv
module vclamp_seq
    import vclamp_pkg::*;
#(
    parameter int VLEN  = 128,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic [SIZE_W-1:0]              size_i,
    input  logic                           quad_i,
    input  logic [AW-1:0]                  group_i,
    input  logic [AW-1:0]                  lo_idx_i,
    input  logic [AW-1:0]                  hi_idx_i,
    input  logic [VLEN-1:0]                clamp_res_i,
    output logic [AW-1:0]                  rd_dst_addr_o,
    output logic [AW-1:0]                  rd_lo_addr_o,
    output logic [AW-1:0]                  rd_hi_addr_o,
    output logic [SIZE_W-1:0]              clamp_size_o,
    output logic                           cm_en_o,
    output logic [AW-1:0]                  cm_base_o,
    output logic [2:0]                     cm_cnt_o,
    output logic [GRP_MAX-1:0][VLEN-1:0]   cm_data_o,
    output logic                           busy_o,
    output logic                           done_o,
    output logic                           err_o
);
    typedef struct packed {
        seq_state_e                  st;
        logic [1:0]                  idx;
        logic [SIZE_W-1:0]           size;
        logic [2:0]                  cnt;
        logic [AW-1:0]               base;
        logic [AW-1:0]               lo;
        logic [AW-1:0]               hi;
        logic                        done;
        logic                        err;
        logic [GRP_MAX-1:0][VLEN-1:0] stage;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [2:0]    req_cnt;
    logic [AW+1:0] req_base;
    logic          req_ok;

    always_comb begin
        req_cnt  = quad_i ? 3'd4 : 3'd2;
        req_base = quad_i ? {group_i, 2'b00} : {1'b0, group_i, 1'b0};
        req_ok   = (int'(req_base) + int'(req_cnt)) <= NREGS;

        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (req_ok) begin
                        seq_d.st   = ST_RUN;
                        seq_d.idx  = '0;
                        seq_d.cnt  = req_cnt;
                        seq_d.base = req_base[AW-1:0];
                        seq_d.size = size_i;
                        seq_d.lo   = lo_idx_i;
                        seq_d.hi   = hi_idx_i;
                    end else begin
                        seq_d.done = 1'b1;
                        seq_d.err  = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                seq_d.stage[seq_q.idx] = clamp_res_i;
                if ({1'b0, seq_q.idx} == seq_q.cnt - 3'd1) begin
                    seq_d.st = ST_COMMIT;
                end else begin
                    seq_d.idx = seq_q.idx + 2'd1;
                end
            end
            ST_COMMIT: begin
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_dst_addr_o = seq_q.base + AW'(seq_q.idx);
    assign rd_lo_addr_o  = seq_q.lo;
    assign rd_hi_addr_o  = seq_q.hi;
    assign clamp_size_o  = seq_q.size;
    assign cm_en_o       = (seq_q.st == ST_COMMIT);
    assign cm_base_o     = seq_q.base;
    assign cm_cnt_o      = seq_q.cnt;
    assign cm_data_o     = seq_q.stage;
    assign busy_o        = (seq_q.st != ST_IDLE);
    assign done_o        = seq_q.done;
    assign err_o         = seq_q.err;

    // Completion follows the group write in the next cycle, without error.
    p_done_after_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cm_en_o |=> (done_o && !err_o && !busy_o));
    // The step counter never leaves the group.
    p_step_in_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_RUN) |-> ({1'b0, seq_q.idx} < seq_q.cnt));
    // Bounds and group stay fixed while a command is running.
    p_cmd_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_RUN) |=> ($stable(seq_q.base) && $stable(seq_q.lo) && $stable(seq_q.hi)));
    // A refused group ends at once with the error flag.
    p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !req_ok) |=> (done_o && err_o && !busy_o));
    // The error flag appears only with completion.
    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);
endmodule

// File: rtl/vclamp_unit.sv
module vclamp_unit
    import vclamp_pkg::*;
#(
    parameter int VLEN  = 128,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start_i,
    input  logic [1:0]        cmd_size_i,
    input  logic              cmd_quad_i,
    input  logic [AW-1:0]     cmd_group_i,
    input  logic [AW-1:0]     cmd_lo_idx_i,
    input  logic [AW-1:0]     cmd_hi_idx_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    input  logic              rf_we_i,
    input  logic [AW-1:0]     rf_waddr_i,
    input  logic [VLEN-1:0]   rf_wdata_i,
    input  logic [AW-1:0]     rf_raddr_i,
    output logic [VLEN-1:0]   rf_rdata_o
);
    logic [AW-1:0]                 rd_dst_addr, rd_lo_addr, rd_hi_addr;
    logic [VLEN-1:0]               rd_dst_data, rd_lo_data, rd_hi_data;
    logic [SIZE_W-1:0]             clamp_size;
    logic [VLEN-1:0]               clamp_res;
    logic                          cm_en;
    logic [AW-1:0]                 cm_base;
    logic [2:0]                    cm_cnt;
    logic [GRP_MAX-1:0][VLEN-1:0]  cm_data;

    vclamp_regfile #(.VLEN(VLEN), .NREGS(NREGS)) u_rf (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_we_i      (rf_we_i),
        .ext_waddr_i   (rf_waddr_i),
        .ext_wdata_i   (rf_wdata_i),
        .ext_raddr_i   (rf_raddr_i),
        .ext_rdata_o   (rf_rdata_o),
        .rd_dst_addr_i (rd_dst_addr),
        .rd_dst_data_o (rd_dst_data),
        .rd_lo_addr_i  (rd_lo_addr),
        .rd_lo_data_o  (rd_lo_data),
        .rd_hi_addr_i  (rd_hi_addr),
        .rd_hi_data_o  (rd_hi_data),
        .cm_en_i       (cm_en),
        .cm_base_i     (cm_base),
        .cm_cnt_i      (cm_cnt),
        .cm_data_i     (cm_data)
    );

    vclamp_lanes #(.VLEN(VLEN)) u_lanes (
        .size_i (clamp_size),
        .lo_i   (rd_lo_data),
        .hi_i   (rd_hi_data),
        .elem_i (rd_dst_data),
        .res_o  (clamp_res)
    );

    vclamp_seq #(.VLEN(VLEN), .NREGS(NREGS)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (cmd_start_i),
        .size_i        (cmd_size_i),
        .quad_i        (cmd_quad_i),
        .group_i       (cmd_group_i),
        .lo_idx_i      (cmd_lo_idx_i),
        .hi_idx_i      (cmd_hi_idx_i),
        .clamp_res_i   (clamp_res),
        .rd_dst_addr_o (rd_dst_addr),
        .rd_lo_addr_o  (rd_lo_addr),
        .rd_hi_addr_o  (rd_hi_addr),
        .clamp_size_o  (clamp_size),
        .cm_en_o       (cm_en),
        .cm_base_o     (cm_base),
        .cm_cnt_o      (cm_cnt),
        .cm_data_o     (cm_data),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .err_o         (err_o)
    );
endmodule

// File: tb/vclamp_unit_test.sv
module vclamp_unit_test;
    localparam int VL = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start_i = 1'b0;
    logic [1:0]    cmd_size_i = '0;
    logic          cmd_quad_i = 1'b0;
    logic [4:0]    cmd_group_i = '0;
    logic [4:0]    cmd_lo_idx_i = '0;
    logic [4:0]    cmd_hi_idx_i = '0;
    logic          busy_o, done_o, err_o;
    logic          rf_we_i = 1'b0;
    logic [4:0]    rf_waddr_i = '0;
    logic [VL-1:0] rf_wdata_i = '0;
    logic [4:0]    rf_raddr_i = '0;
    logic [VL-1:0] rf_rdata_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [VL-1:0] model [32];

    always #5 clk = ~clk;

    vclamp_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start_i), .cmd_size_i(cmd_size_i),
        .cmd_quad_i(cmd_quad_i), .cmd_group_i(cmd_group_i), .cmd_lo_idx_i(cmd_lo_idx_i),
        .cmd_hi_idx_i(cmd_hi_idx_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .rf_we_i(rf_we_i), .rf_waddr_i(rf_waddr_i), .rf_wdata_i(rf_wdata_i),
        .rf_raddr_i(rf_raddr_i), .rf_rdata_o(rf_rdata_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [VL-1:0] ref_clamp(input logic [VL-1:0] lo, input logic [VL-1:0] hi,
                                               input logic [VL-1:0] d, input logic [1:0] sz);
        int w;
        logic [63:0] m, a, b, c, x;
        logic [VL-1:0] r;
        w = 8 << sz;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        r = '0;
        for (int l = 0; l < VL / w; l++) begin
            a = 64'(lo >> (l * w)) & m;
            b = 64'(hi >> (l * w)) & m;
            c = 64'(d  >> (l * w)) & m;
            x = (c > a) ? c : a;
            if (x > b) x = b;
            r = r | (VL'(x) << (l * w));
        end
        return r;
    endfunction

    function automatic logic [VL-1:0] rnd_vec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic load(input int idx, input logic [VL-1:0] v);
        @(negedge clk);
        rf_we_i = 1'b1; rf_waddr_i = 5'(idx); rf_wdata_i = v;
        @(negedge clk);
        rf_we_i = 1'b0;
        model[idx] = v;
    endtask

    task automatic compare_all(input string req);
        for (int r = 0; r < 32; r++) begin
            rf_raddr_i = 5'(r);
            #1;
            check(req, rf_rdata_o, model[r]);
        end
    endtask

    // Issues one command, updates the model and checks the completion timing.
    task automatic run_op(input logic [1:0] sz, input logic quad, input int grp,
                          input int lo, input int hi, input string req);
        int n, base, waited;
        logic [VL-1:0] res [4];
        logic ok;
        n = quad ? 4 : 2;
        base = grp * n;
        ok = (base + n) <= 32;
        for (int k = 0; k < n; k++) begin
            if (ok) res[k] = ref_clamp(model[lo], model[hi], model[base + k], sz);
        end
        @(negedge clk);
        cmd_start_i = 1'b1; cmd_size_i = sz; cmd_quad_i = quad;
        cmd_group_i = 5'(grp); cmd_lo_idx_i = 5'(lo); cmd_hi_idx_i = 5'(hi);
        @(negedge clk);
        cmd_start_i = 1'b0;
        waited = 1;
        while (!done_o && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        // R8: completion latency N+2 cycles; R7: refused group completes after 1 cycle
        check(ok ? "R8 latency" : "R7 latency", VL'(waited), ok ? VL'(n + 2) : VL'(1));
        check(ok ? "R8 no error" : "R7 error flag", VL'(err_o), ok ? VL'(0) : VL'(1));
        if (ok) begin
            for (int k = 0; k < n; k++) model[base + k] = res[k];
        end
        compare_all(req);
        @(negedge clk);
        check("R8 single pulse", VL'(done_o), VL'(0));
    endtask

    task automatic t_reset();
        check("R10 busy", VL'(busy_o), VL'(0));
        check("R10 done", VL'(done_o), VL'(0));
        check("R10 err", VL'(err_o), VL'(0));
        for (int r = 0; r < 32; r++) model[r] = '0;
        compare_all("R10 regs zero");
    endtask

    task automatic t_pair_byte();
        load(1, {16{8'h40}});
        load(2, {16{8'hC0}});
        for (int r = 3; r < 12; r++) load(r, rnd_vec());
        load(6, 128'h00_3F_40_41_7F_80_BF_C0_C1_FF_10_E0_55_AA_01_FE);
        run_op(2'd0, 1'b0, 3, 1, 2, "R2 R4 pair byte clamp");
    endtask

    task automatic t_all_sizes();
        for (int s = 0; s < 4; s++) begin
            load(1, {4{32'h1000_4000}});
            load(2, {4{32'hF000_C000}});
            for (int r = 8; r < 12; r++) load(r, rnd_vec());
            load(9, '1);
            load(10, '0);
            run_op(2'(s), 1'b1, 2, 1, 2, "R1 R5 quad lane widths");
        end
    endtask

    task automatic t_crossed();
        for (int s = 0; s < 4; s++) begin
            load(12, {8{16'hF0A0}});
            load(13, {8{16'h0F0A}});
            load(16, rnd_vec());
            load(17, '1);
            run_op(2'(s), 1'b0, 8, 12, 13, "R3 crossed bounds give high");
        end
    endtask

    task automatic t_overlap();
        for (int r = 4; r < 8; r++) load(r, rnd_vec());
        load(5, {4{32'h2000_0000}});
        load(6, {4{32'hA000_0000}});
        run_op(2'd2, 1'b1, 1, 5, 6, "R6 bounds inside group");
    endtask

    task automatic t_range();
        for (int r = 28; r < 32; r++) load(r, rnd_vec());
        load(0, {2{64'h0000_0000_8000_0000}});
        load(27, {2{64'hFFFF_0000_0000_0000}});
        run_op(2'd3, 1'b1, 8, 0, 27, "R7 four-group refused");
        run_op(2'd0, 1'b0, 16, 0, 27, "R7 pair-group refused");
        run_op(2'd3, 1'b1, 7, 0, 27, "R4 last legal quad");
        run_op(2'd1, 1'b0, 15, 0, 27, "R4 last legal pair");
    endtask

    task automatic t_busy();
        int done_seen;
        logic [VL-1:0] res [4];
        for (int r = 0; r < 4; r++) load(r, rnd_vec());
        for (int r = 20; r < 24; r++) load(r, rnd_vec());
        load(14, {16{8'h30}});
        load(15, {16{8'hB0}});
        for (int k = 0; k < 4; k++) res[k] = ref_clamp(model[14], model[15], model[k], 2'd0);
        @(negedge clk);
        cmd_start_i = 1'b1; cmd_size_i = 2'd0; cmd_quad_i = 1'b1;
        cmd_group_i = 5'd0; cmd_lo_idx_i = 5'd14; cmd_hi_idx_i = 5'd15;
        @(negedge clk);
        cmd_group_i = 5'd5;
        @(negedge clk);
        cmd_start_i = 1'b0;
        done_seen = 0;
        for (int c = 0; c < 14; c++) begin
            if (done_o) done_seen++;
            @(negedge clk);
        end
        check("R9 one completion", VL'(done_seen), VL'(1));
        check("R9 idle after", VL'(busy_o), VL'(0));
        for (int k = 0; k < 4; k++) model[k] = res[k];
        compare_all("R9 second start ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pair_byte();
        t_all_sizes();
        t_crossed();
        t_overlap();
        t_range();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule